// File: doc/BRIEF.md
# Four-Wide In-Order Issue Slotter

This block sits between instruction decode and the execution pipes of an in-order core that fetches four 32-bit instructions at a time. Each fetched packet covers 16 bytes on a 16-byte boundary. Every cycle the block looks at the slots of the current packet that have not yet issued. It picks the longest leading run of them that can go together and names the pipe each one goes to. It also reports how many slots were consumed and whether the fetcher may move on to the next packet.

The core has four pipes. Two are integer pipes that differ: shifts need pipe 0 and branches need pipe 1. The other two are floating-point pipes, one for multiplies and one for adds, and some FP operations may use either one. Each slot arrives with a pre-decoded class, up to two source registers, an optional destination register, and access to a ready vector from the scoreboard. When the fetch entry point is not 16-byte aligned, the slots ahead of the entry instruction are dropped. A packet that only partly issues is retried from its first unissued slot on the next cycle.

Top module: `issue_slotter`

## Requirements
- R1: After reset, with `pkt_valid` low, `issue_mask`, `slot_unit`, `issue_count` and `advance` are all zero, and the first valid packet is treated as freshly fetched.
- R2: On a freshly fetched packet, the entry slot index is `entry_addr[3:2]`. Slots below it never issue and do not block, and `entry_addr[1:0]` has no effect.
- R3: Only a contiguous leading run of the remaining slots issues. The first slot that cannot issue stops issue, and every later slot waits even if it could go.
- R4: Class code 0 (general integer) takes integer pipe 0 (unit code 0) if it is still free in this cycle, else integer pipe 1 (unit code 1), else it blocks.
- R5: Class code 1 (shift) issues only to unit 0, and class code 2 (branch) issues only to unit 1. If that pipe is already taken by an earlier slot, the slot blocks.
- R6: Class code 3 (FP multiply) needs unit 2 and class code 4 (FP add) needs unit 3. Class code 5 (either FP) takes unit 2 if free, else unit 3. Every pipe takes at most one slot per cycle.
- R7: A slot blocks when one of its used sources (`slot_src_use` bit 0 for source a, bit 1 for source b), or its written destination, equals the destination written by an earlier slot that issues in the same cycle.
- R8: A slot blocks when one of its used sources is marked not ready (bit clear) in `reg_ready`.
- R9: After a partial issue, `advance` is low and the next valid cycle resumes at the first unissued slot. The entry offset is not applied again.
- R10: `advance` is high exactly when every remaining slot issues in that cycle. The following valid cycle treats the inputs as a new packet. `issue_count` equals the number of set bits in `issue_mask`.
- R11: Class codes 6 and 7 are reserved and never issue. A reserved slot stops issue at its position.
- R12: While `pkt_valid` is low, nothing issues, `advance` is low, and the progress through the current packet is kept.
- R13: `slot_unit` holds a 2-bit unit code per slot, with slot k in bits [2k+1:2k]. It is zero for every slot that does not issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_valid | input | 1 | The slot inputs hold a valid packet this cycle |
| entry_addr | input | 32 | Byte address of the entry instruction of the packet |
| slot_class | input | 12 | 3-bit class code per slot, slot k in bits [3k+2:3k] |
| slot_src_a | input | 20 | First source register number per slot, 5 bits each |
| slot_src_b | input | 20 | Second source register number per slot, 5 bits each |
| slot_src_use | input | 8 | Per slot: bit 0 uses source a, bit 1 uses source b |
| slot_dst | input | 20 | Destination register number per slot, 5 bits each |
| slot_dst_we | input | 4 | Per slot: the destination is written |
| reg_ready | input | 32 | Scoreboard: bit r set means register r may be read |
| issue_mask | output | 4 | Slots issuing this cycle |
| slot_unit | output | 8 | 2-bit unit code per slot: 0 int pipe 0, 1 int pipe 1, 2 FP mul, 3 FP add |
| issue_count | output | 3 | Number of slots issuing this cycle |
| advance | output | 1 | All remaining slots issue; fetch the next packet |

## Verification
The bench targets the places where the asymmetric pipes interact with greedy slot order. It covers a shift placed behind a general integer op that already took pipe 0, two branches in a row, and a third FP op after both FP pipes are taken. A design that reassigned pipes out of order, or skipped a blocked slot, would issue too many slots there. Dependences are exercised through source a, source b and a shared destination, followed by the cycle that retries the blocked slot. A design that applied the entry offset again, or forgot which slots had already gone, would then reissue or drop slots. The bench also covers unaligned entries with junk in the discarded slots, a reserved class in mid-packet, a source the scoreboard holds back, and an idle cycle in the middle of a packet.

// File: rtl/slot_pkg.sv
`timescale 1ns/1ps
package slot_pkg;
  localparam int CLS_W  = 3;
  localparam int PIPE_W = 2;

  typedef enum logic [CLS_W-1:0] {
    C_INT    = 3'd0,
    C_SHIFT  = 3'd1,
    C_BRANCH = 3'd2,
    C_FMUL   = 3'd3,
    C_FADD   = 3'd4,
    C_FANY   = 3'd5,
    C_RSV6   = 3'd6,
    C_RSV7   = 3'd7
  } op_class_e;

  typedef enum logic [PIPE_W-1:0] {
    P_INT0 = 2'd0,
    P_INT1 = 2'd1,
    P_FMUL = 2'd2,
    P_FADD = 2'd3
  } pipe_e;
endpackage

// File: rtl/slot_hazard.sv
`timescale 1ns/1ps
// Per-slot readiness: scoreboard check on used sources and
// same-packet dependence against earlier remaining writers.
module slot_hazard #(
  parameter int NSLOT  = 4,
  parameter int REG_AW = 5,
  localparam int NREG  = 1 << REG_AW
) (
  input  logic [NSLOT-1:0]        remaining,
  input  logic [NSLOT*REG_AW-1:0] src_a,
  input  logic [NSLOT*REG_AW-1:0] src_b,
  input  logic [NSLOT*2-1:0]      src_use,
  input  logic [NSLOT*REG_AW-1:0] dst,
  input  logic [NSLOT-1:0]        dst_we,
  input  logic [NREG-1:0]         reg_ready,
  output logic [NSLOT-1:0]        hz_ok
);
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic [REG_AW-1:0] sa, sb, sd;
    logic              use_a, use_b, rd_ok, clash, ok_k;

    assign sa    = src_a[k*REG_AW +: REG_AW];
    assign sb    = src_b[k*REG_AW +: REG_AW];
    assign sd    = dst[k*REG_AW +: REG_AW];
    assign use_a = src_use[2*k];
    assign use_b = src_use[2*k+1];

    always_comb begin
      rd_ok = 1'b1;
      if (use_a && !reg_ready[sa]) rd_ok = 1'b0;
      if (use_b && !reg_ready[sb]) rd_ok = 1'b0;
    end

    // Earlier remaining slots all issue if this slot is reached,
    // so comparing against every remaining writer ahead is exact.
    always_comb begin
      clash = 1'b0;
      for (int j = 0; j < k; j++) begin
        if (remaining[j] && dst_we[j]) begin
          if (use_a && (sa == dst[j*REG_AW +: REG_AW]))     clash = 1'b1;
          if (use_b && (sb == dst[j*REG_AW +: REG_AW]))     clash = 1'b1;
          if (dst_we[k] && (sd == dst[j*REG_AW +: REG_AW])) clash = 1'b1;
        end
      end
    end

    assign ok_k     = rd_ok && !clash;
    assign hz_ok[k] = ok_k;
  end
endmodule

// File: rtl/slot_pipe_alloc.sv
`timescale 1ns/1ps
// Greedy in-order pipe assignment with prefix stop.
module slot_pipe_alloc
  import slot_pkg::*;
#(
  parameter int NSLOT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [NSLOT-1:0]        remaining,
  input  logic [NSLOT-1:0]        hz_ok,
  input  logic [NSLOT*CLS_W-1:0]  slot_class,
  output logic [NSLOT-1:0]        issue,
  output logic [NSLOT*PIPE_W-1:0] slot_unit
);
  always_comb begin
    logic      i0_busy, i1_busy, fm_busy, fa_busy, stop, go;
    pipe_e     pick;
    op_class_e c;
    i0_busy   = 1'b0;
    i1_busy   = 1'b0;
    fm_busy   = 1'b0;
    fa_busy   = 1'b0;
    stop      = 1'b0;
    issue     = '0;
    slot_unit = '0;
    for (int k = 0; k < NSLOT; k++) begin
      c    = op_class_e'(slot_class[k*CLS_W +: CLS_W]);
      go   = 1'b0;
      pick = P_INT0;
      if (enable && remaining[k] && !stop) begin
        if (hz_ok[k]) begin
          case (c)
            C_INT: begin
              if (!i0_busy)      begin go = 1'b1; pick = P_INT0; end
              else if (!i1_busy) begin go = 1'b1; pick = P_INT1; end
            end
            C_SHIFT:  if (!i0_busy) begin go = 1'b1; pick = P_INT0; end
            C_BRANCH: if (!i1_busy) begin go = 1'b1; pick = P_INT1; end
            C_FMUL:   if (!fm_busy) begin go = 1'b1; pick = P_FMUL; end
            C_FADD:   if (!fa_busy) begin go = 1'b1; pick = P_FADD; end
            C_FANY: begin
              if (!fm_busy)      begin go = 1'b1; pick = P_FMUL; end
              else if (!fa_busy) begin go = 1'b1; pick = P_FADD; end
            end
            default: go = 1'b0;
          endcase
        end
        if (!go) begin
          stop = 1'b1;
        end else begin
          case (pick)
            P_INT0:  i0_busy = 1'b1;
            P_INT1:  i1_busy = 1'b1;
            P_FMUL:  fm_busy = 1'b1;
            default: fa_busy = 1'b1;
          endcase
          issue[k] = 1'b1;
          slot_unit[k*PIPE_W +: PIPE_W] = pick;
        end
      end
    end
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_chk
    a_r5_shift_pipe0: assert property (@(posedge clk) disable iff (!rst_n)
      (issue[k] && slot_class[k*CLS_W +: CLS_W] == C_SHIFT)
        |-> slot_unit[k*PIPE_W +: PIPE_W] == P_INT0);
    a_r5_branch_pipe1: assert property (@(posedge clk) disable iff (!rst_n)
      (issue[k] && slot_class[k*CLS_W +: CLS_W] == C_BRANCH)
        |-> slot_unit[k*PIPE_W +: PIPE_W] == P_INT1);
    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_class[k*CLS_W +: CLS_W] == C_RSV6 ||
       slot_class[k*CLS_W +: CLS_W] == C_RSV7) |-> !issue[k]);
    a_r13_idle_unit: assert property (@(posedge clk) disable iff (!rst_n)
      !issue[k] |-> slot_unit[k*PIPE_W +: PIPE_W] == '0);
    if (k > 0) begin : g_prefix
      a_r3_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (issue[k] && remaining[k-1]) |-> issue[k-1]);
    end
    for (genvar j = 0; j < k; j++) begin : g_pair
      a_r6_one_per_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        (issue[j] && issue[k])
          |-> slot_unit[j*PIPE_W +: PIPE_W] != slot_unit[k*PIPE_W +: PIPE_W]);
    end
  end
endmodule

// File: rtl/slot_window.sv
`timescale 1ns/1ps
// Tracks which slots of the current packet are still to issue.
module slot_window #(
  parameter int NSLOT       = 4,
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4,
  localparam int SIDX_W     = $clog2(NSLOT),
  localparam int OFS_LO     = $clog2(INSTR_BYTES),
  localparam int OFS_HI     = OFS_LO + SIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [ADDR_W-1:0] entry_addr,
  input  logic [NSLOT-1:0]  issue,
  output logic [NSLOT-1:0]  remaining,
  output logic              advance
);
  logic [SIDX_W-1:0] ofs;
  logic [NSLOT-1:0]  lead;
  logic              fresh_q, fresh_d;
  logic [NSLOT-1:0]  pend_q, pend_d;
  logic              unused_addr_bits;

  assign ofs = entry_addr[OFS_LO +: SIDX_W];
  assign unused_addr_bits = ^{entry_addr[ADDR_W-1:OFS_HI], entry_addr[OFS_LO-1:0]};

  for (genvar k = 0; k < NSLOT; k++) begin : g_lead
    assign lead[k] = (SIDX_W'(k) >= ofs);
  end

  assign remaining = fresh_q ? lead : pend_q;
  assign advance   = pkt_valid && ((issue & remaining) == remaining);

  always_comb begin
    fresh_d = fresh_q;
    pend_d  = pend_q;
    if (advance) begin
      fresh_d = 1'b1;
      pend_d  = '0;
    end else begin
      fresh_d = 1'b0;
      pend_d  = remaining & ~issue;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b1;
      pend_q  <= '0;
    end else if (pkt_valid) begin
      fresh_q <= fresh_d;
      pend_q  <= pend_d;
    end
  end

  a_r2_no_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && fresh_q) |-> ((issue & ~lead) == '0));
  a_r9_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !advance) |=> ((remaining & $past(issue)) == '0));
endmodule

// File: rtl/issue_slotter.sv
`timescale 1ns/1ps
module issue_slotter
  import slot_pkg::*;
#(
  parameter int NSLOT       = 4,
  parameter int ADDR_W      = 32,
  parameter int REG_AW      = 5,
  parameter int INSTR_BYTES = 4,
  localparam int NREG       = 1 << REG_AW,
  localparam int CNT_W      = $clog2(NSLOT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pkt_valid,
  input  logic [ADDR_W-1:0]       entry_addr,
  input  logic [NSLOT*CLS_W-1:0]  slot_class,
  input  logic [NSLOT*REG_AW-1:0] slot_src_a,
  input  logic [NSLOT*REG_AW-1:0] slot_src_b,
  input  logic [NSLOT*2-1:0]      slot_src_use,
  input  logic [NSLOT*REG_AW-1:0] slot_dst,
  input  logic [NSLOT-1:0]        slot_dst_we,
  input  logic [NREG-1:0]         reg_ready,
  output logic [NSLOT-1:0]        issue_mask,
  output logic [NSLOT*PIPE_W-1:0] slot_unit,
  output logic [CNT_W-1:0]        issue_count,
  output logic                    advance
);
  logic rst_meta_q, rst_sync_q, rst_int_n;
  logic [NSLOT-1:0] remaining, hz_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_int_n = rst_sync_q;

  slot_window #(.NSLOT(NSLOT), .ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_window (
    .clk(clk), .rst_n(rst_int_n), .pkt_valid(pkt_valid), .entry_addr(entry_addr),
    .issue(issue_mask), .remaining(remaining), .advance(advance));

  slot_hazard #(.NSLOT(NSLOT), .REG_AW(REG_AW)) u_hazard (
    .remaining(remaining), .src_a(slot_src_a), .src_b(slot_src_b),
    .src_use(slot_src_use), .dst(slot_dst), .dst_we(slot_dst_we),
    .reg_ready(reg_ready), .hz_ok(hz_ok));

  slot_pipe_alloc #(.NSLOT(NSLOT)) u_alloc (
    .clk(clk), .rst_n(rst_int_n), .enable(pkt_valid), .remaining(remaining),
    .hz_ok(hz_ok), .slot_class(slot_class), .issue(issue_mask), .slot_unit(slot_unit));

  always_comb begin
    issue_count = '0;
    for (int k = 0; k < NSLOT; k++) issue_count = issue_count + CNT_W'(issue_mask[k]);
  end

  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pkt_valid |-> (issue_mask == '0 && !advance));
  a_r10_adv_nonzero: assert property (@(posedge clk) disable iff (!rst_int_n)
    advance |-> issue_count != '0);

  for (genvar k = 0; k < NSLOT; k++) begin : g_chk
    a_r8_src_a_ready: assert property (@(posedge clk) disable iff (!rst_int_n)
      (issue_mask[k] && slot_src_use[2*k]) |-> reg_ready[slot_src_a[k*REG_AW +: REG_AW]]);
    a_r8_src_b_ready: assert property (@(posedge clk) disable iff (!rst_int_n)
      (issue_mask[k] && slot_src_use[2*k+1]) |-> reg_ready[slot_src_b[k*REG_AW +: REG_AW]]);
    for (genvar j = 0; j < k; j++) begin : g_pair
      a_r7_no_raw: assert property (@(posedge clk) disable iff (!rst_int_n)
        (issue_mask[j] && issue_mask[k] && slot_dst_we[j] && slot_src_use[2*k])
          |-> slot_src_a[k*REG_AW +: REG_AW] != slot_dst[j*REG_AW +: REG_AW]);
      a_r7_no_waw: assert property (@(posedge clk) disable iff (!rst_int_n)
        (issue_mask[j] && issue_mask[k] && slot_dst_we[j] && slot_dst_we[k])
          |-> slot_dst[k*REG_AW +: REG_AW] != slot_dst[j*REG_AW +: REG_AW]);
    end
  end
endmodule

// File: tb/issue_slotter_test.sv
`timescale 1ns/1ps
module issue_slotter_test;
  localparam int CLK_NS = 20;

  logic        clk, rst_n, pkt_valid;
  logic [31:0] addr;
  logic [11:0] cls;
  logic [19:0] sa, sb, dst;
  logic [7:0]  suse;
  logic [3:0]  dwe;
  logic [31:0] rdy;
  logic [3:0]  mask;
  logic [7:0]  unit;
  logic [2:0]  cnt;
  logic        adv;

  int checks = 0;
  int errors = 0;

  issue_slotter uut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .entry_addr(addr),
    .slot_class(cls), .slot_src_a(sa), .slot_src_b(sb), .slot_src_use(suse),
    .slot_dst(dst), .slot_dst_we(dwe), .reg_ready(rdy),
    .issue_mask(mask), .slot_unit(unit), .issue_count(cnt), .advance(adv));

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input logic [3:0] em, input logic [7:0] eu,
                     input logic [2:0] ec, input logic ea);
    checks++;
    if (mask !== em || unit !== eu || cnt !== ec || adv !== ea) begin
      errors++;
      $display("FAIL %s: mask=%b unit=%h count=%0d adv=%b expected mask=%b unit=%h count=%0d adv=%b",
               tag, mask, unit, cnt, adv, em, eu, ec, ea);
    end
  endtask

  task automatic defaults();
    addr = '0; cls = '0; sa = '0; sb = '0; dst = '0; suse = '0; dwe = '0; rdy = '1;
  endtask

  task automatic set_cls(input int k, input logic [2:0] c);
    cls[k*3 +: 3] = c;
  endtask

  task automatic do_reset();
    pkt_valid = 1'b0;
    defaults();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic nextc();
    @(negedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pkt_valid = 1'b0; defaults();
    #2;
    chk("R1 in reset", 4'b0, 8'h00, 3'd0, 1'b0);
    do_reset();
    #2;
    chk("R1 after reset idle", 4'b0, 8'h00, 3'd0, 1'b0);
  endtask

  task automatic t_int_pair();
    do_reset();
    pkt_valid = 1'b1; #2;
    chk("R4 two int pipes", 4'b0011, 8'h04, 3'd2, 1'b0);
    nextc();
    chk("R9 resume at slot 2", 4'b1100, 8'h40, 3'd2, 1'b1);
    nextc();
    chk("R10 new packet after advance", 4'b0011, 8'h04, 3'd2, 1'b0);
  endtask

  task automatic t_asym();
    do_reset();
    set_cls(0, 3'd2); set_cls(1, 3'd1); set_cls(2, 3'd0); set_cls(3, 3'd5);
    pkt_valid = 1'b1; #2;
    chk("R5 branch+shift fill int pipes", 4'b0011, 8'h01, 3'd2, 1'b0);
    do_reset();
    set_cls(1, 3'd1);
    pkt_valid = 1'b1; #2;
    chk("R5 shift behind int blocks", 4'b0001, 8'h00, 3'd1, 1'b0);
    do_reset();
    set_cls(0, 3'd2); set_cls(1, 3'd2);
    pkt_valid = 1'b1; #2;
    chk("R5 second branch blocks", 4'b0001, 8'h01, 3'd1, 1'b0);
    do_reset();
    set_cls(0, 3'd1); set_cls(1, 3'd2); set_cls(2, 3'd3); set_cls(3, 3'd4);
    pkt_valid = 1'b1; #2;
    chk("R13 full mix unit codes", 4'b1111, 8'hE4, 3'd4, 1'b1);
  endtask

  task automatic t_fp();
    do_reset();
    set_cls(0, 3'd5); set_cls(1, 3'd5); set_cls(2, 3'd5); set_cls(3, 3'd0);
    pkt_valid = 1'b1; #2;
    chk("R6 either-FP fills mul then add", 4'b0011, 8'h0E, 3'd2, 1'b0);
    do_reset();
    set_cls(0, 3'd4); set_cls(1, 3'd5);
    pkt_valid = 1'b1; #2;
    chk("R6 either-FP after add takes mul", 4'b1111, 8'h4B, 3'd4, 1'b1);
    do_reset();
    set_cls(0, 3'd3); set_cls(1, 3'd3);
    pkt_valid = 1'b1; #2;
    chk("R6 second FP mul blocks", 4'b0001, 8'h02, 3'd1, 1'b0);
  endtask

  task automatic t_unaligned();
    do_reset();
    addr = 32'h1000_0008;
    pkt_valid = 1'b1; #2;
    chk("R2 entry slot 2", 4'b1100, 8'h40, 3'd2, 1'b1);
    do_reset();
    addr = 32'h1000_000D;
    pkt_valid = 1'b1; #2;
    chk("R2 entry slot 3 low bits ignored", 4'b1000, 8'h00, 3'd1, 1'b1);
    do_reset();
    addr = 32'h0000_0004;
    set_cls(0, 3'd6); set_cls(3, 3'd3);
    pkt_valid = 1'b1; #2;
    chk("R2 discarded reserved slot does not block", 4'b1110, 8'h90, 3'd3, 1'b1);
  endtask

  task automatic t_dep();
    do_reset();
    dst[0 +: 5] = 5'd5; dwe[0] = 1'b1;
    sa[5 +: 5] = 5'd5; suse[2] = 1'b1;
    set_cls(2, 3'd3); set_cls(3, 3'd4);
    pkt_valid = 1'b1; #2;
    chk("R7 RAW on source a", 4'b0001, 8'h00, 3'd1, 1'b0);
    nextc();
    chk("R9 blocked slot retried", 4'b1110, 8'hE0, 3'd3, 1'b1);
    do_reset();
    dst[0 +: 5] = 5'd5; dwe[0] = 1'b1;
    sb[5 +: 5] = 5'd5; suse[3] = 1'b1;
    pkt_valid = 1'b1; #2;
    chk("R7 RAW on source b", 4'b0001, 8'h00, 3'd1, 1'b0);
    do_reset();
    dst[0 +: 5] = 5'd7; dwe[0] = 1'b1;
    set_cls(1, 3'd4); dst[5 +: 5] = 5'd7; dwe[1] = 1'b1;
    pkt_valid = 1'b1; #2;
    chk("R7 WAW blocks", 4'b0001, 8'h00, 3'd1, 1'b0);
    do_reset();
    dst[0 +: 5] = 5'd5; dwe[0] = 1'b1;
    sa[5 +: 5] = 5'd6; suse[2] = 1'b1;
    pkt_valid = 1'b1; #2;
    chk("R7 no false dependence", 4'b0011, 8'h04, 3'd2, 1'b0);
  endtask

  task automatic t_ready();
    do_reset();
    rdy[9] = 1'b0;
    sa[0 +: 5] = 5'd9; suse[0] = 1'b1;
    pkt_valid = 1'b1; #2;
    chk("R8 not-ready source stalls slot 0", 4'b0000, 8'h00, 3'd0, 1'b0);
    nextc();
    chk("R8 stall persists", 4'b0000, 8'h00, 3'd0, 1'b0);
    rdy[9] = 1'b1; #1;
    chk("R8 issues once ready", 4'b0011, 8'h04, 3'd2, 1'b0);
    do_reset();
    rdy[9] = 1'b0;
    set_cls(1, 3'd3); set_cls(2, 3'd4);
    sb[10 +: 5] = 5'd9; suse[5] = 1'b1;
    pkt_valid = 1'b1; #2;
    chk("R3 stop at not-ready slot 2", 4'b0011, 8'h08, 3'd2, 1'b0);
  endtask

  task automatic t_reserved();
    do_reset();
    set_cls(1, 3'd6);
    pkt_valid = 1'b1; #2;
    chk("R11 reserved stops issue", 4'b0001, 8'h00, 3'd1, 1'b0);
    nextc();
    chk("R11 reserved never issues", 4'b0000, 8'h00, 3'd0, 1'b0);
    do_reset();
    set_cls(0, 3'd7);
    pkt_valid = 1'b1; #2;
    chk("R11 class 7 in slot 0", 4'b0000, 8'h00, 3'd0, 1'b0);
  endtask

  task automatic t_idle();
    do_reset();
    pkt_valid = 1'b1; #2;
    chk("R12 first half", 4'b0011, 8'h04, 3'd2, 1'b0);
    nextc();
    pkt_valid = 1'b0; addr = 32'h0000_0004; #1;
    chk("R12 idle issues nothing", 4'b0000, 8'h00, 3'd0, 1'b0);
    nextc();
    pkt_valid = 1'b1; #1;
    chk("R12 progress kept across idle", 4'b1100, 8'h40, 3'd2, 1'b1);
  endtask

  initial begin
    #(CLK_NS * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_int_pair();
    t_asym();
    t_fp();
    t_unaligned();
    t_dep();
    t_ready();
    t_reserved();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule